// File: doc/BRIEF.md
# Per-Timeslot Receive Payload Conditioner

This block sits on the octet-wide receive payload path of a 24-slot DS1 framer. Each received octet belongs to one DS0 timeslot. A frame-start strobe marks slot 0, and an internal counter numbers the slots that follow. A 4-bit operation code for each slot picks what happens to the octet. The octet can pass unchanged. It can have a fixed bit mask XORed into it. It can be replaced by a constant, by a busy code tagged with the slot number, or by a programmable idle octet. It can also be replaced by the next step of an A-law or u-law milliwatt tone, or by eight bits from a 15-stage PRBS generator. Two further codes mark a slot as a data-link (D) channel or a signaling (E) channel. Such a slot passes through unchanged and raises its own flag.

A simple write port loads the per-slot codes and the idle octet into a staging copy. The staging copy becomes active on the next frame-start octet, so the configuration never changes part way through a frame. Every result leaves through one output register, one clock after its input octet.

Top module: `ds0_cond`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier. `out_octet`, `out_ts` and the flags are the result for the octet accepted one clock earlier.
- R2: An octet accepted with `frame_start` high is slot 0. Each later accepted octet takes the next slot number, and idle cycles leave the count unchanged. `out_ts` reports the slot number.
- R3: Code 0 passes the octet unchanged. Codes 1 to 5 XOR the octet with, in order: 0xFF, 0x55 (even bits 0,2,4,6), 0xAA (odd bits), 0x80 (MSB only) and 0x7F (all but the MSB).
- R4: Code 6 outputs 0x7F, code 8 outputs 0xFF and code 12 outputs 0x1A.
- R5: Code 7 outputs binary 111 in bits 7:5 and the 5-bit slot number in bits 4:0.
- R6: Code 11 outputs the active idle octet. A write with `idle_we` stages the value in `idle_code`, and the staged value becomes active at the next frame start. The idle octet is 0xFF after reset.
- R7: Code 9 outputs entry i of the A-law table 34,21,21,34,B4,A1,A1,B4 (hex). The 3-bit index i starts at 0. It advances by one at each frame start that follows a frame in which code 9 was output at least once.
- R8: Code 10 does the same from its own index, using the u-law table 1E,0B,0B,1E,9E,8B,8B,9E (hex).
- R9: Code 13 outputs bits 14:7 of a 15-bit LFSR. The LFSR is seeded to 0x7FFF at reset. After supplying an octet it advances eight steps, each step being state = {state[13:0], state[14]^state[13]}. It advances only for octets it supplies.
- R10: Codes 14 (D) and 15 (E) pass the octet unchanged. Code 14 sets `out_dchan` and code 15 sets `out_echan`. Both flags are low for all other codes and whenever `out_valid` is low.
- R11: A code write (`cfg_we`, slot `cfg_addr`) affects only octets from the next frame start on, including a write made during a frame. Writes with `cfg_addr` of 24 or more are ignored.
- R12: After reset, `out_valid`, `out_octet`, `out_ts` and both flags are 0, and every slot uses code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Marks the accepted octet as slot 0 |
| in_valid | input | 1 | Input octet present |
| in_octet | input | 8 | Received payload octet |
| cfg_we | input | 1 | Stage an operation code |
| cfg_addr | input | 5 | Slot whose code is written |
| cfg_sel | input | 4 | Operation code |
| idle_we | input | 1 | Stage a new idle octet |
| idle_code | input | 8 | Idle octet value |
| out_valid | output | 1 | Output octet present |
| out_octet | output | 8 | Conditioned octet |
| out_ts | output | 5 | Slot number of the output octet |
| out_dchan | output | 1 | Output slot is a D channel |
| out_echan | output | 1 | Output slot is an E channel |

## Verification
Every result comes from the single output register, so it appears one clock after the octet is accepted. The bench drives each octet on a falling edge and compares all outputs on the next falling edge, half a cycle after that register loads. Configuration changes show up first in the slot-0 result of the following frame. The milliwatt indices and the PRBS state only move on accepted octets, so the bench model updates its own copies at the same points.

// File: rtl/ds0_cond.sv
module ds0_cond #(
  parameter int NUM_TS = 24,
  parameter logic [14:0] PRBS_SEED = 15'h7FFF,
  parameter logic [7:0] IDLE_RESET = 8'hFF,
  localparam int TSW = $clog2(NUM_TS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           in_valid,
  input  logic [7:0]     in_octet,
  input  logic           cfg_we,
  input  logic [TSW-1:0] cfg_addr,
  input  logic [3:0]     cfg_sel,
  input  logic           idle_we,
  input  logic [7:0]     idle_code,
  output logic           out_valid,
  output logic [7:0]     out_octet,
  output logic [TSW-1:0] out_ts,
  output logic           out_dchan,
  output logic           out_echan
);
  localparam logic [TSW-1:0] LAST = TSW'(NUM_TS - 1);

  logic [NUM_TS-1:0][3:0] pend_sel, act_sel;
  logic [7:0]  idle_pend, idle_act;
  logic [TSW-1:0] ts_cnt;
  logic [2:0]  a_idx, u_idx;
  logic        a_used, u_used;
  logic [14:0] prbs;
  logic [7:0]  res;

  function automatic logic [14:0] prbs_adv8(input logic [14:0] s);
    logic [14:0] t;
    t = s;
    for (int k = 0; k < 8; k++) t = {t[13:0], t[14] ^ t[13]};
    return t;
  endfunction

  function automatic logic [7:0] alaw_tone(input logic [2:0] i);
    case (i)
      3'd0, 3'd3: return 8'h34;
      3'd1, 3'd2: return 8'h21;
      3'd4, 3'd7: return 8'hB4;
      default:    return 8'hA1;
    endcase
  endfunction

  function automatic logic [7:0] ulaw_tone(input logic [2:0] i);
    case (i)
      3'd0, 3'd3: return 8'h1E;
      3'd1, 3'd2: return 8'h0B;
      3'd4, 3'd7: return 8'h9E;
      default:    return 8'h8B;
    endcase
  endfunction

  wire           fs       = in_valid & frame_start;
  wire [TSW-1:0] ts_now   = fs ? '0 : ts_cnt;
  wire [3:0]     sel_now  = fs ? pend_sel[ts_now] : act_sel[ts_now];
  wire [7:0]     idle_now = fs ? idle_pend : idle_act;
  wire [2:0]     a_cur    = a_idx + {2'b0, fs & a_used};
  wire [2:0]     u_cur    = u_idx + {2'b0, fs & u_used};
  wire           emit_a   = in_valid && sel_now == 4'd9;
  wire           emit_u   = in_valid && sel_now == 4'd10;
  wire           emit_p   = in_valid && sel_now == 4'd13;

  always_comb begin
    case (sel_now)
      4'd1:  res = ~in_octet;
      4'd2:  res = in_octet ^ 8'h55;
      4'd3:  res = in_octet ^ 8'hAA;
      4'd4:  res = in_octet ^ 8'h80;
      4'd5:  res = in_octet ^ 8'h7F;
      4'd6:  res = 8'h7F;
      4'd7:  res = {3'b111, 5'(ts_now)};
      4'd8:  res = 8'hFF;
      4'd9:  res = alaw_tone(a_cur);
      4'd10: res = ulaw_tone(u_cur);
      4'd11: res = idle_now;
      4'd12: res = 8'h1A;
      4'd13: res = prbs[14:7];
      default: res = in_octet;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_sel  <= '0;
      act_sel   <= '0;
      idle_pend <= IDLE_RESET;
      idle_act  <= IDLE_RESET;
      ts_cnt    <= '0;
      a_idx     <= '0;
      u_idx     <= '0;
      a_used    <= 1'b0;
      u_used    <= 1'b0;
      prbs      <= PRBS_SEED;
      out_valid <= 1'b0;
      out_octet <= '0;
      out_ts    <= '0;
      out_dchan <= 1'b0;
      out_echan <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr <= LAST) pend_sel[cfg_addr] <= cfg_sel;
      if (idle_we) idle_pend <= idle_code;
      out_valid <= in_valid;
      if (in_valid) begin
        if (fs) begin
          act_sel  <= pend_sel;
          idle_act <= idle_pend;
          a_idx    <= a_cur;
          u_idx    <= u_cur;
          a_used   <= emit_a;
          u_used   <= emit_u;
        end else begin
          a_used <= a_used | emit_a;
          u_used <= u_used | emit_u;
        end
        ts_cnt    <= (ts_now == LAST) ? '0 : ts_now + 1'b1;
        if (emit_p) prbs <= prbs_adv8(prbs);
        out_octet <= res;
        out_ts    <= ts_now;
        out_dchan <= sel_now == 4'd14;
        out_echan <= sel_now == 4'd15;
      end else begin
        out_dchan <= 1'b0;
        out_echan <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ds0_cond_chk.sv
module ds0_cond_chk #(
  parameter int NUM_TS = 24,
  localparam int TSW = $clog2(NUM_TS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_start,
  input logic                in_valid,
  input logic [7:0]          in_octet,
  input logic                out_valid,
  input logic [7:0]          out_octet,
  input logic [TSW-1:0]      out_ts,
  input logic                out_dchan,
  input logic                out_echan,
  input logic [TSW-1:0]      ts_cnt,
  input logic [NUM_TS*4-1:0] act_sel
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  a_r2_ts_restart: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && frame_start |=> out_ts == '0);

  a_r2_ts_count: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !frame_start |=> out_ts == $past(ts_cnt));

  a_r10_dchan_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_dchan |-> out_valid && out_octet == $past(in_octet));

  a_r10_echan_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_echan |-> out_valid && out_octet == $past(in_octet));

  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_dchan && out_echan));

  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && frame_start) |=> $stable(act_sel));
endmodule

bind ds0_cond ds0_cond_chk #(.NUM_TS(NUM_TS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .in_octet(in_octet), .out_valid(out_valid), .out_octet(out_octet),
  .out_ts(out_ts), .out_dchan(out_dchan), .out_echan(out_echan),
  .ts_cnt(ts_cnt), .act_sel(act_sel)
);

// File: tb/ds0_cond_bench.sv
`timescale 1ns/1ps
module ds0_cond_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, in_valid = 0, cfg_we = 0, idle_we = 0;
  logic [7:0] in_octet = 0, idle_code = 0;
  logic [4:0] cfg_addr = 0;
  logic [3:0] cfg_sel = 0;
  logic out_valid, out_dchan, out_echan;
  logic [7:0] out_octet;
  logic [4:0] out_ts;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [3:0] m_pend [24];
  logic [3:0] m_act  [24];
  logic [7:0] m_idle_p = 8'hFF, m_idle_a = 8'hFF;
  int m_ts = 0;
  logic [2:0] m_ai = 0, m_ui = 0;
  bit m_au = 0, m_uu = 0;
  logic [14:0] m_lfsr = 15'h7FFF;
  logic [7:0] a_tab [8] = '{8'h34,8'h21,8'h21,8'h34,8'hB4,8'hA1,8'hA1,8'hB4};
  logic [7:0] u_tab [8] = '{8'h1E,8'h0B,8'h0B,8'h1E,8'h9E,8'h8B,8'h8B,8'h9E};

  ds0_cond u_ds0_cond (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .in_octet(in_octet), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_sel(cfg_sel),
    .idle_we(idle_we), .idle_code(idle_code), .out_valid(out_valid),
    .out_octet(out_octet), .out_ts(out_ts), .out_dchan(out_dchan), .out_echan(out_echan)
  );

  always #4 clk = ~clk;

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R3";
      4'd6, 4'd8, 4'd12: return "R4";
      4'd7:  return "R5";
      4'd9:  return "R7";
      4'd10: return "R8";
      4'd11: return "R6";
      4'd13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit fs, input logic [7:0] d,
                      input bit we, input int addr, input logic [3:0] sel,
                      input bit iwe, input logic [7:0] icode);
    logic [3:0] s;
    logic [7:0] e, oct;
    int ts;
    frame_start = fs; in_valid = v; in_octet = d;
    cfg_we = we; cfg_addr = 5'(addr); cfg_sel = sel;
    idle_we = iwe; idle_code = icode;
    s = 0; e = 0; ts = 0;
    if (v) begin
      if (fs) begin
        for (int i = 0; i < 24; i++) m_act[i] = m_pend[i];
        m_idle_a = m_idle_p;
        if (m_au) m_ai = m_ai + 3'd1;
        if (m_uu) m_ui = m_ui + 3'd1;
        m_au = 0; m_uu = 0;
        m_ts = 0;
      end
      ts = m_ts;
      s = m_act[ts];
      case (s)
        4'd1: e = ~d;
        4'd2: e = d ^ 8'h55;
        4'd3: e = d ^ 8'hAA;
        4'd4: e = d ^ 8'h80;
        4'd5: e = d ^ 8'h7F;
        4'd6: e = 8'h7F;
        4'd7: e = 8'hE0 | 8'(ts);
        4'd8: e = 8'hFF;
        4'd9: begin e = a_tab[m_ai]; m_au = 1; end
        4'd10: begin e = u_tab[m_ui]; m_uu = 1; end
        4'd11: e = m_idle_a;
        4'd12: e = 8'h1A;
        4'd13: begin
          oct = 0;
          for (int k = 0; k < 8; k++) begin
            oct = {oct[6:0], m_lfsr[14]};
            m_lfsr = {m_lfsr[13:0], m_lfsr[14] ^ m_lfsr[13]};
          end
          e = oct;
        end
        default: e = d;
      endcase
      m_ts++;
    end
    if (we && addr < 24) m_pend[addr] = sel;
    if (iwe) m_idle_p = icode;
    @(negedge clk);
    chk("R1", int'(out_valid), int'(v));
    if (v) begin
      chk(req_of(s), int'(out_octet), int'(e));
      chk("R2", int'(out_ts), ts);
      chk("R10", int'({out_dchan, out_echan}), int'({s == 4'd14, s == 4'd15}));
    end else begin
      chk("R10", int'({out_dchan, out_echan}), 0);
    end
    frame_start = 0; in_valid = 0; cfg_we = 0; idle_we = 0;
  endtask

  task automatic run_frame(input int k);
    for (int t = 0; t < 24; t++) begin
      logic [7:0] d;
      d = 8'((t * 37 + k * 101 + 13) ^ (k << 3));
      if (k % 2 == 1 && t % 7 == 3) step(0, 0, 8'hA5, 0, 0, 0, 0, 0);
      if (t == 5 && k > 0) begin
        // R11: mid-frame write to a later slot must not change this frame
        int a;
        a = 12 + k % 12;
        step(1, t == 0, d, 1, a, m_pend[a] ^ 4'h1, 0, 0);
      end else if (t == 10 && k % 2 == 1) begin
        step(1, t == 0, d, 0, 0, 0, 1, 8'(k * 29 + 3)); // R6 staged idle
      end else begin
        step(1, t == 0, d, 0, 0, 0, 0, 0);
      end
    end
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 24; i++) begin m_pend[i] = 0; m_act[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R12", int'(out_valid), 0);
    chk("R12", int'(out_octet), 0);
    chk("R12", int'(out_ts), 0);
    chk("R12", int'({out_dchan, out_echan}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12", int'(out_valid), 0);
    run_frame(0); // R12: reset codes are pass-through
    for (int k = 1; k < 40; k++) begin
      for (int i = 0; i < 24; i++)
        step(0, 0, 8'h00, 1, i, 4'((i * (k % 5 + 1) + k) % 16), 0, 0);
      // R11: addresses 24..31 are ignored
      step(0, 0, 8'h00, 1, 24 + k % 8, 4'd1, 0, 0);
      run_frame(k);
    end
    step(0, 0, 8'h00, 0, 0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule